// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block is a full-duplex synchronous serial port that software drives through a small register port. A control word turns the port on, picks the bus role (bus master or bus slave), can route the serial output straight back into the receiver, and can keep the slave's data output off the wire. Writing the data word queues a frame in a transmit FIFO. Reading the data word removes the oldest received frame from a receive FIFO. A status word shows whether the transmit FIFO has room and whether the receive FIFO holds data.

When it is the master, the port generates the serial clock by dividing the system clock by a fixed even ratio. It pulls the select line low for each frame and shifts the frame out most significant bit first, in clock mode 0. When it is the slave, it passes the incoming clock, data and select lines through two-flop synchronisers and acts on the detected clock edges. Each frame shifted out brings one frame in, and that frame is queued in the receive FIFO as soon as its last bit is sampled. Frame length is set by an input from 4 to 16 bits.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset the control word reads 0 and the status word reads TNF=1 (bit 0) and RNE=0 (bit 1). Both output enables are low, ssel_n_o is high and sclk_o is low.
- R2: The register addresses are: 0 control, 1 data, 2 status. Control bit 0 selects loopback. When it is set, the receiver samples the port's own serial output: mosi_o in master mode, miso_o in slave mode. When it is clear, the master samples miso_i.
- R3: Control bit 2 (0 = master, 1 = slave) takes a written value only when the current enable bit (control bit 1) is 0. A write made while the port is enabled leaves the mode bit unchanged.
- R4: While enable is 0, mst_oe and miso_oe are low, no frame is shifted, and queued transmit data stays in the FIFO.
- R5: mst_oe is high only when the port is enabled in master mode. miso_oe is high only when the port is enabled in slave mode with control bit 3 (output disable) at 0. Bit 3 has no effect in master mode.
- R6: Each FIFO holds 8 frames. TNF is 0 only when the transmit FIFO is full, and RNE is 1 when the receive FIFO is not empty. A data write to a full FIFO is dropped. A data read from an empty FIFO reads 0 and changes nothing.
- R7: A received frame shorter than 16 bits reads right-justified in bits 15:0, with the unused upper bits 0. Transmit data for a short frame is taken from its low-order bits.
- R8: In master mode ssel_n_o goes low for each frame and returns high for at least one cycle between frames. Data is sent MSB first: mosi_o changes while sclk_o is low, and the input is sampled on the rising edge of sclk_o. sclk_o stays low while ssel_n_o is high.
- R9: In slave mode the port loads the next transmit frame (or 0 when the FIFO is empty) when the synchronised ssel_n_i falls. It then drives miso_o MSB first, samples mosi_i on each synchronised rising edge of sclk_i, and shifts out the next bit on each falling edge.
- R10: In master mode one sclk_o period lasts CLK_DIV system clock cycles.
- R11: Frames are sent in the order they were written, and reads return received frames oldest first.
- R12: Each completed frame pushes exactly one entry into the receive FIFO, in the cycle its last bit is sampled. A push and a bus pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_bits | input | 5 | Frame length in bits, 4 to 16 |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the data address) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read strobe |
| sclk_o | output | 1 | Serial clock driven as master |
| mosi_o | output | 1 | Master serial data out |
| ssel_n_o | output | 1 | Master select, active low |
| mst_oe | output | 1 | Enable for the three master outputs |
| sclk_i | input | 1 | Serial clock received as slave |
| mosi_i | input | 1 | Serial data received as slave |
| ssel_n_i | input | 1 | Select received as slave, active low |
| miso_i | input | 1 | Serial data received as master |
| miso_o | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Enable for miso_o |

## Verification
The receive FIFO can be written by the shifter and read by the bus in the same cycle: the shifter completes a frame while software pops the entry queued before it. The bench first leaves one frame waiting in the receive FIFO and starts a second one. It then issues a single data read at a sweep of offsets after the second write, so that one offset lands exactly on the cycle that pushes the second frame. At every offset the bench expects to read the first frame, then the second, then 0 with RNE clear. A lost push or a doubled pop shows up as a wrong value or a missing frame.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Register addresses on the bus port
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // Control word, packed so that bit 0 is loopback
  typedef struct packed {
    logic sod;    // bit 3: slave output disable
    logic slave;  // bit 2: 0 master, 1 slave
    logic en;     // bit 1: port enable
    logic loop;   // bit 0: internal loopback
  } ssp_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_SLV  = 2'd3
  } ssp_state_e;

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop  && (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; only written slots are ever read
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wdata;
  end

  assign head  = (cnt_q == '0) ? '0 : mem_q[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned FBW     = 5,
  parameter int unsigned CLK_DIV = 4,
  localparam int unsigned HALF   = CLK_DIV / 2,
  localparam int unsigned DVW    = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           slave,
  input  logic           loop,
  input  logic [FBW-1:0] frame_bits,
  input  logic           tx_empty,
  input  logic [DW-1:0]  tx_data,
  output logic           tx_pop,
  output logic           rx_push,
  output logic [DW-1:0]  rx_data,
  input  logic           sclk_i,
  input  logic           mosi_i,
  input  logic           ssel_n_i,
  input  logic           miso_i,
  output logic           sclk_o,
  output logic           mosi_o,
  output logic           ssel_n_o,
  output logic           miso_o
);

  ssp_state_e     st_q, st_d;
  logic [DVW-1:0] div_q, div_d;
  logic [FBW-1:0] bit_q, bit_d, fb_q, fb_d;
  logic [DW-1:0]  tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d;
  logic [DW-1:0]  tx_aligned;
  logic           sclk_s, mosi_s, ssel_s;
  logic           sclk_d1, ssel_d1;
  logic           sclk_rise, sclk_fall, ssel_fall;
  logic           half_done, m_in, s_in;

  // Slave inputs pass through two flops before any use
  ssp_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ssel_n_i, sclk_i, mosi_i}),
    .q     ({ssel_s, sclk_s, mosi_s})
  );

  assign sclk_rise = sclk_s && !sclk_d1;
  assign sclk_fall = !sclk_s && sclk_d1;
  assign ssel_fall = !ssel_s && ssel_d1;

  // MSB of the frame moves to bit DW-1 so both roles shift left
  assign tx_aligned = tx_data << (FBW'(DW) - frame_bits);
  assign half_done  = (div_q == DVW'(HALF - 1));

  assign sclk_o   = (st_q == ST_HIGH);
  assign ssel_n_o = !((st_q == ST_LOW) || (st_q == ST_HIGH));
  assign mosi_o   = !ssel_n_o && tx_sh_q[DW-1];
  assign miso_o   = (st_q == ST_SLV) && tx_sh_q[DW-1];

  assign m_in = loop ? mosi_o : miso_i;
  assign s_in = loop ? miso_o : mosi_s;

  always_comb begin
    st_d    = st_q;
    div_d   = div_q;
    bit_d   = bit_q;
    fb_d    = fb_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    if (!en) begin
      st_d  = ST_IDLE;
      div_d = '0;
      bit_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if ((!slave && !tx_empty) || (slave && ssel_fall)) begin
            tx_pop  = !tx_empty;
            tx_sh_d = tx_aligned;
            rx_sh_d = '0;
            bit_d   = '0;
            div_d   = '0;
            fb_d    = frame_bits;
            st_d    = slave ? ST_SLV : ST_LOW;
          end
        end
        ST_LOW: begin
          if (half_done) begin
            div_d   = '0;
            st_d    = ST_HIGH;
            rx_sh_d = {rx_sh_q[DW-2:0], m_in};
            bit_d   = bit_q + 1'b1;
            rx_push = (bit_q + 1'b1 == fb_q);
          end else begin
            div_d = div_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (half_done) begin
            div_d = '0;
            if (bit_q == fb_q) begin
              st_d = ST_IDLE;
            end else begin
              st_d    = ST_LOW;
              tx_sh_d = tx_sh_q << 1;
            end
          end else begin
            div_d = div_q + 1'b1;
          end
        end
        ST_SLV: begin
          if (ssel_s) begin
            st_d = ST_IDLE;
          end else if (sclk_rise && (bit_q != fb_q)) begin
            rx_sh_d = {rx_sh_q[DW-2:0], s_in};
            bit_d   = bit_q + 1'b1;
            rx_push = (bit_q + 1'b1 == fb_q);
          end else if (sclk_fall) begin
            tx_sh_d = tx_sh_q << 1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign rx_data = rx_sh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      fb_q    <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      sclk_d1 <= 1'b0;
      ssel_d1 <= 1'b1;
    end else begin
      st_q    <= st_d;
      div_q   <= div_d;
      bit_q   <= bit_d;
      fb_q    <= fb_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
      sclk_d1 <= sclk_s;
      ssel_d1 <= ssel_s;
    end
  end

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned FBW        = 5,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned CLK_DIV    = 4,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FBW-1:0] frame_bits,
  input  logic [1:0]     bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           sclk_o,
  output logic           mosi_o,
  output logic           ssel_n_o,
  output logic           mst_oe,
  input  logic           sclk_i,
  input  logic           mosi_i,
  input  logic           ssel_n_i,
  input  logic           miso_i,
  output logic           miso_o,
  output logic           miso_oe
);

  logic [1:0]    rst_sq;
  logic          rst_int_n;
  ssp_cfg_t      cfg_q, cfg_d;
  logic          tx_wr, rx_rd, tx_pop, rx_push;
  logic [DW-1:0] tx_head, rx_head, rx_word;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_empty, tnf, rne;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_int_n = rst_sq[1];

  assign tx_wr = bus_wr && (bus_addr == ADDR_DATA);
  assign rx_rd = bus_rd && (bus_addr == ADDR_DATA);

  always_comb begin
    cfg_d = cfg_q;
    if (bus_wr && (bus_addr == ADDR_CTRL)) begin
      cfg_d.loop = bus_wdata[0];
      cfg_d.en   = bus_wdata[1];
      cfg_d.sod  = bus_wdata[3];
      if (!cfg_q.en) cfg_d.slave = bus_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cfg_q <= '0;
    else            cfg_q <= cfg_d;
  end

  ssp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (tx_wr),
    .wdata (bus_wdata),
    .pop   (tx_pop),
    .head  (tx_head),
    .count (tx_cnt)
  );

  ssp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (rx_push),
    .wdata (rx_word),
    .pop   (rx_rd),
    .head  (rx_head),
    .count (rx_cnt)
  );

  assign tx_empty = (tx_cnt == '0);
  assign tnf      = (tx_cnt != CW'(FIFO_DEPTH));
  assign rne      = (rx_cnt != '0);

  ssp_engine #(.DW(DW), .FBW(FBW), .CLK_DIV(CLK_DIV)) u_eng (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en         (cfg_q.en),
    .slave      (cfg_q.slave),
    .loop       (cfg_q.loop),
    .frame_bits (frame_bits),
    .tx_empty   (tx_empty),
    .tx_data    (tx_head),
    .tx_pop     (tx_pop),
    .rx_push    (rx_push),
    .rx_data    (rx_word),
    .sclk_i     (sclk_i),
    .mosi_i     (mosi_i),
    .ssel_n_i   (ssel_n_i),
    .miso_i     (miso_i),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .ssel_n_o   (ssel_n_o),
    .miso_o     (miso_o)
  );

  assign mst_oe  = cfg_q.en && !cfg_q.slave;
  assign miso_oe = cfg_q.en && cfg_q.slave && !cfg_q.sod;

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {{(DW-4){1'b0}}, cfg_q};
      ADDR_DATA: bus_rdata = rx_head;
      ADDR_STAT: bus_rdata = {{(DW-2){1'b0}}, rne, tnf};
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ssp_ctrl_chk.sv
module ssp_ctrl_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_slave,
  input logic          cfg_sod,
  input logic          mst_oe,
  input logic          miso_oe,
  input logic          sclk_o,
  input logic          ssel_n_o,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (!mst_oe && !miso_oe)); // R4

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && $past(cfg_en)) |-> $stable(cfg_slave)); // R3

  AST_SOD_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slave && cfg_sod) |-> !miso_oe); // R5

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    ssel_n_o |-> !sclk_o); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH))); // R6

endmodule

bind ssp_ctrl ssp_ctrl_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_q.en),
  .cfg_slave (cfg_q.slave),
  .cfg_sod   (cfg_q.sod),
  .mst_oe    (mst_oe),
  .miso_oe   (miso_oe),
  .sclk_o    (sclk_o),
  .ssel_n_o  (ssel_n_o),
  .tx_cnt    (tx_cnt),
  .rx_cnt    (rx_cnt)
);

// File: tb/sim_ssp_ctrl.sv
module sim_ssp_ctrl;

  logic        clk, rst_n;
  logic [4:0]  frame_bits;
  logic [1:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        sclk_o, mosi_o, ssel_n_o, mst_oe;
  logic        sclk_i, mosi_i, ssel_n_i, miso_i;
  logic        miso_o, miso_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int ssel_frames = 0;
  int rise_prev = 0;
  int rise_last = 0;
  logic [15:0] cap = '0;

  ssp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .frame_bits(frame_bits),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .ssel_n_o(ssel_n_o), .mst_oe(mst_oe),
    .sclk_i(sclk_i), .mosi_i(mosi_i), .ssel_n_i(ssel_n_i), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe(miso_oe)
  );

  // 100 MHz: 10 ns period
  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Bits seen on the wire at each master clock rise (MSB first)
  always @(posedge sclk_o) begin
    cap       <= {cap[14:0], mosi_o};
    rise_prev <= rise_last;
    rise_last <= cyc;
  end
  always @(negedge ssel_n_o) ssel_frames <= ssel_frames + 1;

  typedef struct packed {
    logic [4:0]  fb;
    logic [15:0] tx;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{5'd16, 16'hA55A, 16'hA55A},
    '{5'd8,  16'h12C3, 16'h00C3},
    '{5'd4,  16'hFFFF, 16'h000F},
    '{5'd12, 16'h0ABC, 16'h0ABC},
    '{5'd5,  16'hFFFF, 16'h001F},
    '{5'd13, 16'h1234, 16'h1234},
    '{5'd16, 16'h8001, 16'h8001}
  };

  function automatic logic [15:0] lowmask(input logic [4:0] fb);
    logic [16:0] m;
    m = (17'd1 << fb) - 17'd1;
    return m[15:0];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_rne(input int limit);
    logic [15:0] s;
    for (int i = 0; i < limit; i++) begin
      bus_read(2'd2, s);
      if (s[1]) return;
    end
  endtask

  // One slave frame driven from the bench: mosi pattern in, miso bits out
  task automatic slave_frame(input logic [15:0] din, input int nb, output logic [15:0] seen);
    seen = '0;
    ssel_n_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = nb - 1; b >= 0; b--) begin
      mosi_i = din[b];
      repeat (8) @(negedge clk);
      sclk_i = 1'b1;
      seen = {seen[14:0], miso_o};
      repeat (8) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ssel_n_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [15:0] seen;
    int f0;
    rst_n = 1'b0; frame_bits = 5'd8; bus_addr = '0; bus_wr = 0; bus_rd = 0;
    bus_wdata = '0; sclk_i = 0; mosi_i = 0; ssel_n_i = 1; miso_i = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(2'd0, r); check("R1 ctrl", r, 16'h0000);
    bus_read(2'd2, r); check("R1 status", r, 16'h0001);
    check("R1 pins", {12'b0, mst_oe, miso_oe, ssel_n_o, sclk_o}, 16'h0002);

    // R2 R7 R8 vector table in master loopback
    bus_write(2'd0, 16'h0003);
    foreach (VEC[i]) begin
      frame_bits = VEC[i].fb;
      f0 = ssel_frames;
      bus_write(2'd1, VEC[i].tx);
      wait_rne(200);
      bus_read(2'd1, r);
      check("R2 R7 loopback data", r, VEC[i].exp);
      check("R8 msb-first wire bits", cap & lowmask(VEC[i].fb), VEC[i].exp);
      check("R8 one select per frame", 16'(ssel_frames - f0), 16'd1);
    end
    // R10 last vector was 16 bits; neighbouring rises are one period apart
    check("R10 sclk period", 16'(rise_last - rise_prev), 16'd4);

    // R2 no loopback: master samples miso_i
    bus_write(2'd0, 16'h0002);
    miso_i = 1'b1; frame_bits = 5'd8;
    bus_write(2'd1, 16'h0000);
    wait_rne(200);
    bus_read(2'd1, r); check("R2 external miso", r, 16'h00FF);
    miso_i = 1'b0;

    // R3 mode bit locked while enabled
    bus_write(2'd0, 16'h0006);
    bus_read(2'd0, r); check("R3 locked", r, 16'h0002);
    bus_write(2'd0, 16'h0000);
    bus_write(2'd0, 16'h0004);
    bus_read(2'd0, r); check("R3 free while off", r, 16'h0004);

    // R5 output enables
    bus_write(2'd0, 16'h000E);
    check("R5 sod mutes", {14'b0, mst_oe, miso_oe}, 16'h0000);
    bus_write(2'd0, 16'h0006);
    check("R5 slave drives", {14'b0, mst_oe, miso_oe}, 16'h0001);
    bus_write(2'd0, 16'h0000);
    bus_write(2'd0, 16'h000A);
    check("R5 sod ignored in master", {14'b0, mst_oe, miso_oe}, 16'h0002);
    bus_write(2'd0, 16'h0000);

    // R6 R4 R11 overflow while disabled, then drain in order
    frame_bits = 5'd8;
    for (int k = 0; k < 9; k++) bus_write(2'd1, 16'h0010 + 16'(k));
    bus_read(2'd2, r); check("R6 full TNF low", r, 16'h0000);
    f0 = ssel_frames;
    repeat (50) @(negedge clk);
    check("R4 no frame while off", {14'b0, ssel_n_o, mst_oe}, 16'h0002);
    check("R4 no select pulses", 16'(ssel_frames - f0), 16'd0);
    bus_write(2'd0, 16'h0003);
    repeat (400) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      bus_read(2'd1, r); check("R11 order", r, 16'h0010 + 16'(k));
    end
    bus_read(2'd1, r); check("R6 dropped write / empty read", r, 16'h0000);
    bus_read(2'd2, r); check("R6 RNE clear", r, 16'h0001);

    // R9 slave frame from the bench
    bus_write(2'd0, 16'h0000);
    bus_write(2'd0, 16'h0004);
    bus_write(2'd1, 16'h005A);
    bus_write(2'd0, 16'h0006);
    slave_frame(16'h00C3, 8, seen);
    check("R9 slave miso bits", seen, 16'h005A);
    bus_read(2'd1, r); check("R9 slave received", r, 16'h00C3);
    slave_frame(16'h0081, 8, seen);
    check("R9 empty fifo sends zero", seen, 16'h0000);
    bus_read(2'd1, r); check("R9 second frame", r, 16'h0081);

    // R12 sweep a pop across the receive push cycle
    bus_write(2'd0, 16'h0000);
    bus_write(2'd0, 16'h0003);
    frame_bits = 5'd4;
    for (int off = 8; off < 26; off++) begin
      bus_write(2'd1, 16'h0005);
      wait_rne(100);
      bus_write(2'd1, 16'h000A);
      repeat (off) @(negedge clk);
      bus_read(2'd1, r); check("R12 first frame", r, 16'h0005);
      repeat (40) @(negedge clk);
      bus_read(2'd1, r); check("R12 second frame", r, 16'h000A);
      bus_read(2'd1, r); check("R12 nothing extra", r, 16'h0000);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule